// File: doc/BRIEF.md
# Shift-Based Fixed-Point Exponential Unit

This block approximates e^y for a non-positive fixed-point argument without any multiplier or lookup table. The argument is given as an unsigned magnitude `x_mag` with `FRAC` fractional bits, so y = -x_mag / 2^FRAC. The magnitude is scaled by log2(e), taken as binary 1.0111, using a shift-and-add constant multiplier. The multiplier's three operands are first compressed by a carry-save row and then summed by one adder.

The scaled value t = -m / 2^FRAC is split into an integer part u and a fraction v in (0,1]. The term 2^v is replaced by the line v + d. The result is then shifted right by -u.

A pass-select input chooses between two bias constants. In the second pass, a logarithm magnitude `ln_mag` is subtracted from the argument first. Because y is non-positive, this subtraction is done by adding the two magnitudes.

The unit is a single lane with a three-stage pipeline: multiply, split/fit and shift. A valid flag travels alongside the data.

Top module: `exp_shift_unit`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly three clock cycles. While reset is held, `out_valid` is 0.
- R2: The scaled magnitude is m = A + floor(A/2) - floor(A/16), where A is the working magnitude (integer arithmetic, with `FRAC` fractional bits).
- R3: The split takes ip = floor(m / 2^FRAC) and fr = m mod 2^FRAC. It forms u = -(ip+1) and v = (2^FRAC - fr) / 2^FRAC. A zero fraction therefore gives v = 1.
- R4: With `second_pass` = 0, A = `x_mag` and the fit is fit = (2^FRAC - fr) + `BIAS1`, in units of 2^-FRAC.
- R5: With `second_pass` = 1, A = `x_mag` + `ln_mag` and `BIAS2` replaces `BIAS1`.
- R6: The output is fit shifted right by (ip+1). When ip+1 is at least FRAC+2, the output is exactly 0.
- R7: After reset is released, and before any valid input, `out_valid` stays 0.
- R8: Every valid output is at most 2^FRAC, that is, at most 1.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| second_pass | input | 1 | 0: first pass with BIAS1; 1: subtract ln_mag and use BIAS2 |
| x_mag | input | IN_W | Magnitude of the non-positive argument, FRAC fractional bits |
| ln_mag | input | IN_W | Magnitude of the log value, FRAC fractional bits |
| out_valid | output | 1 | Result valid |
| out_val | output | FRAC+2 | Approximated e^y, FRAC fractional bits |

## Verification
Each result appears three clock edges after its inputs are applied.

The bench drives inputs on the falling edge and samples outputs on the falling edge. It keeps its own three-deep queue of expected values, so each comparison is made against the stimulus from exactly three falling edges earlier.

`out_valid` is compared every cycle, so a result that arrives one cycle early or late is reported. The checker module covers the same delay with properties written using three-cycle implications.

// File: rtl/exp_shift_unit.sv
module exp_shift_unit #(
  parameter int IN_W  = 12,
  parameter int FRAC  = 8,
  parameter int BIAS1 = 245,
  parameter int BIAS2 = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              second_pass,
  input  logic [IN_W-1:0]   x_mag,
  input  logic [IN_W-1:0]   ln_mag,
  output logic              out_valid,
  output logic [FRAC+1:0]   out_val
);
  localparam int Q     = IN_W + 1;
  localparam int P_W   = Q + 1;
  localparam int IP_W  = P_W - FRAC;
  localparam int SH_W  = IP_W + 1;
  localparam int FIT_W = FRAC + 2;

  // stage 1: magnitude and carry-save constant multiply
  logic [Q-1:0]   mag;
  logic [P_W-1:0] a, b, f, cs_s, cs_c, prod;

  assign mag  = second_pass ? ({1'b0, x_mag} + {1'b0, ln_mag}) : {1'b0, x_mag};
  assign a    = {1'b0, mag};
  assign b    = a >> 1;
  assign f    = ~(a >> 4);
  assign cs_s = a ^ b ^ f;
  assign cs_c = ((a & b) | (a & f) | (b & f)) << 1;
  assign prod = cs_s + cs_c + P_W'(1);

  logic           v1, pass1;
  logic [P_W-1:0] prod_r;

  always_ff @(posedge clk) begin
    if (!rst_n) v1 <= 1'b0;
    else        v1 <= in_valid;
    prod_r <= prod;
    pass1  <= second_pass;
  end

  // stage 2: split into integer/fraction, linear fit
  logic [IP_W-1:0]  ip;
  logic [FRAC-1:0]  fr;
  logic [FRAC:0]    vnum;
  logic [FIT_W-1:0] bias, fit;
  logic [SH_W-1:0]  sh;

  assign ip   = prod_r[P_W-1:FRAC];
  assign fr   = prod_r[FRAC-1:0];
  assign vnum = {1'b1, {FRAC{1'b0}}} - {1'b0, fr};
  assign bias = pass1 ? FIT_W'(BIAS2) : FIT_W'(BIAS1);
  assign fit  = {1'b0, vnum} + bias;
  assign sh   = {1'b0, ip} + SH_W'(1);

  logic             v2;
  logic [FIT_W-1:0] fit_r;
  logic [SH_W-1:0]  sh_r;

  always_ff @(posedge clk) begin
    if (!rst_n) v2 <= 1'b0;
    else        v2 <= v1;
    fit_r <= fit;
    sh_r  <= sh;
  end

  // stage 3: right shift by -u with saturation to zero
  logic [FIT_W-1:0] shifted;
  assign shifted = (sh_r >= SH_W'(FIT_W)) ? '0 : (fit_r >> sh_r);

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= v2;
    out_val <= shifted;
  end
endmodule

// File: rtl/exp_shift_unit_chk.sv
module exp_shift_unit_chk #(
  parameter int IN_W  = 12,
  parameter int FRAC  = 8,
  parameter int BIAS1 = 245,
  parameter int BIAS2 = 240
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            second_pass,
  input logic [IN_W-1:0] x_mag,
  input logic [IN_W-1:0] ln_mag,
  input logic            out_valid,
  input logic [FRAC+1:0] out_val
);
  localparam int FIT_W = FRAC + 2;
  localparam logic [FRAC+1:0] ONE = (FRAC+2)'(1) << FRAC;
  localparam logic [FRAC+1:0] Z1  = (FRAC+2)'(((1 << FRAC) + BIAS1) >> 1);
  localparam logic [FRAC+1:0] Z2  = (FRAC+2)'(((1 << FRAC) + BIAS2) >> 1);
  localparam logic [IN_W-1:0] BIG = IN_W'(FIT_W << FRAC);

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_valid_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_out_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_val <= ONE));

  assert_zero_arg_pass1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !second_pass && x_mag == '0) |-> ##3 (out_val == Z1));

  assert_zero_arg_pass2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && second_pass && x_mag == '0 && ln_mag == '0) |-> ##3 (out_val == Z2));

  assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !second_pass && x_mag >= BIG) |-> ##3 (out_val == '0));
endmodule

bind exp_shift_unit exp_shift_unit_chk #(
  .IN_W(IN_W), .FRAC(FRAC), .BIAS1(BIAS1), .BIAS2(BIAS2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .second_pass(second_pass),
  .x_mag(x_mag), .ln_mag(ln_mag), .out_valid(out_valid), .out_val(out_val)
);

// File: tb/tb_exp_shift_unit.sv
module tb_exp_shift_unit;
  localparam int IN_W  = 12;
  localparam int FRAC  = 8;
  localparam int BIAS1 = 245;
  localparam int BIAS2 = 240;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic second_pass = 1'b0;
  logic [IN_W-1:0] x_mag = '0;
  logic [IN_W-1:0] ln_mag = '0;
  logic out_valid;
  logic [FRAC+1:0] out_val;

  always #4 clk = ~clk;

  exp_shift_unit #(.IN_W(IN_W), .FRAC(FRAC), .BIAS1(BIAS1), .BIAS2(BIAS2)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .second_pass(second_pass),
    .x_mag(x_mag), .ln_mag(ln_mag), .out_valid(out_valid), .out_val(out_val)
  );

  int checks = 0;
  int fails  = 0;

  bit    qv[3];
  int    qe[3];
  string qt[3];

  function automatic int model(int x, int ln, bit p2);
    int a, m, ip, fr, fit, s;
    a   = p2 ? x + ln : x;
    m   = a + (a >> 1) - (a >> 4);
    ip  = m >> FRAC;
    fr  = m % (1 << FRAC);
    fit = (1 << FRAC) - fr + (p2 ? BIAS2 : BIAS1);
    s   = ip + 1;
    return (s >= FRAC + 2) ? 0 : (fit >> s);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, bit p2, int x, int ln, string tag);
    @(negedge clk);
    check("R1 valid", int'(out_valid), int'(qv[2]));
    if (qv[2]) begin
      check(qt[2], int'(out_val), qe[2]);
      check("R8 range", int'(out_val <= (1 << FRAC)), 1);
    end
    qv[2] = qv[1]; qe[2] = qe[1]; qt[2] = qt[1];
    qv[1] = qv[0]; qe[1] = qe[0]; qt[1] = qt[0];
    in_valid    = v;
    second_pass = p2;
    x_mag       = IN_W'(x);
    ln_mag      = IN_W'(ln);
    qv[0] = v;
    qe[0] = model(x, ln, p2);
    qt[0] = tag;
  endtask

  initial begin
    #800000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    for (int i = 0; i < 3; i++) begin qv[i] = 1'b0; qe[i] = 0; qt[i] = ""; end
    repeat (3) @(negedge clk);
    check("R7 reset out_valid", int'(out_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R7 idle out_valid", int'(out_valid), 0);
    end
    step(1, 0, 0, 0, "R3 zero fraction v=1");
    step(1, 0, 0, 0, "R4 pass1 zero arg");
    step(1, 1, 0, 0, "R5 pass2 zero arg");
    step(1, 0, 16, 0, "R2 sub term");
    step(1, 0, 256, 0, "R2 one");
    step(1, 0, 17, 0, "R2 truncation");
    step(1, 1, 100, 300, "R5 ln added");
    step(1, 0, 4095, 0, "R6 saturate");
    step(1, 0, 1420, 0, "R6 boundary");
    step(1, 0, 1430, 0, "R6 boundary");
    step(0, 0, 55, 0, "R1 bubble");
    step(1, 1, 4095, 4095, "R6 pass2 saturate");
    for (int i = 0; i < 400; i++) begin
      bit v, p2;
      int x, ln;
      v  = ($urandom % 4) != 0;
      p2 = $urandom % 2;
      x  = $urandom % ((i % 2) ? 1024 : 4096);
      ln = $urandom % 1024;
      step(v, p2, x, ln, p2 ? "R5 random" : "R4 random");
    end
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R1 drain");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule